// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block keeps the interrupt status of two disk channels. Each channel's pending flag is visible in two configuration bytes at once: a legacy status byte of its own, and a shared mode byte that also carries one block bit per channel. The pending flag is stored once per channel and shown in both bytes, so the two copies always agree. Software acknowledges a channel through either copy with a write-one-to-clear. A single level-sensitive output, `irq_out`, is raised while any channel is pending and not blocked.

Each channel is tracked by a three-state machine:
- **IDLE**: the request line is low and nothing is pending.
- **PEND**: the line has risen and the flag is set.
- **ACKED**: software has cleared the flag while the line is still high.

The transitions are:
- **rise**: IDLE to PEND.
- **ack**: PEND to ACKED, on a write-one-to-clear while the line stays high.
- **drop**: PEND or ACKED to IDLE, when the line falls.

A request-line edge takes priority over a clear in the same cycle.

The configuration port is 32 bits wide and word addressed, with byte enables. The byte offsets are:
- Channel 0 legacy byte at 0x50: word 0x14, lane 0.
- Channel 1 legacy byte at 0x57: word 0x15, lane 3.
- Mode byte at 0x71: word 0x1C, lane 1.

Top module: `chan_irq_mirror`

## Requirements
- R1: After reset, words 0x14, 0x15 and 0x1C read 0 and `irq_out` is low.
- R2: A rising request line sets the channel's flag on the next clock edge, in both of its copies. Channel 0 appears at word 0x14 bit 2 and word 0x1C bit 10. Channel 1 appears at word 0x15 bit 28 and word 0x1C bit 11.
- R3: A falling request line clears the channel's flag in both copies on the next clock edge.
- R4: Writing a 1 to a flag bit in a legacy byte clears that channel's flag in both copies. Writing 0 there changes nothing. No write ever sets a flag.
- R5: Writing a 1 to a flag bit in the mode byte (bit 10 for channel 0, bit 11 for channel 1) clears that flag in both copies.
- R6: A flag cleared while its request line stays high remains clear. It sets again only after the line goes low and then high.
- R7: The block bits are word 0x1C bits 12 (channel 0) and 13 (channel 1). Any write to the mode byte loads them from the write data, and they read back. All other bits of the three bytes read 0.
- R8: `irq_out` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1). It follows any flag or block change in the same cycle that change becomes visible.
- R9: A byte whose byte enable is low is not affected by a write.
- R10: A request-line edge and a clear in the same cycle: a rise leaves the flag set, and a fall leaves the channel in IDLE.
- R11: Writes to any other word have no effect, and other words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | 2 | Per-channel interrupt request levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| irq_out | output | 1 | Shared level interrupt |

## Verification
The bench targets an acknowledge made while the request line is still high. A design that re-armed on the level instead of the edge would raise the flag again in the next cycle. It clears through each copy in turn and reads the other copy, which catches a mirror that drifts apart or a clear that reaches only one byte. It also exercises:
- a clear and a line edge in the same cycle, where a wrong priority either loses a fresh request or leaves the channel stuck in ACKED;
- byte enables held low and writes of zeros or all-ones, which expose a write path that sets flags;
- every mix of block bits, which catches a gate applied to the wrong channel.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_PEND  = 2'd1,
        CH_ACKED = 2'd2
    } ch_state_e;

    localparam int CFG_ADDR_W = 6;
    localparam int CFG_DATA_W = 32;
    localparam int CFG_LANES  = CFG_DATA_W / 8;

    localparam logic [7:0] LEG0_OFS  = 8'h50;
    localparam logic [7:0] LEG1_OFS  = 8'h57;
    localparam logic [7:0] MODE_OFS  = 8'h71;

    localparam int LEG0_BIT  = 2;
    localparam int LEG1_BIT  = 4;
    localparam int MODE_ST0  = 2;
    localparam int MODE_ST1  = 3;
    localparam int MODE_BLK0 = 4;
    localparam int MODE_BLK1 = 5;
endpackage

// File: rtl/irqm_chan_fsm.sv
module irqm_chan_fsm
    import irqm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic pend
);
    ch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  state_d = req ? CH_PEND : CH_IDLE;
            CH_PEND: begin
                if (!req)     state_d = CH_IDLE;
                else if (clr) state_d = CH_ACKED;
                else          state_d = CH_PEND;
            end
            CH_ACKED: state_d = req ? CH_ACKED : CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == CH_PEND);
    end

    // R2 and R10: a rising line always lands in PEND, even with a clear in the same cycle
    a_r2_rise_to_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && req) |=> pend);
    // R3: a falling line always drops the flag
    a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && !req) |=> !pend);
    // R6: an acknowledged channel stays quiet while its line is held
    a_r6_ack_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACKED && req) |=> !pend);
    // R4: only a line edge can raise the flag
    a_r4_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !(state_q == CH_IDLE && req)) |=> !pend);
endmodule

// File: rtl/irqm_cfg_port.sv
module irqm_cfg_port
    import irqm_pkg::*;
#(
    parameter int         ADDR_W = CFG_ADDR_W,
    parameter logic [7:0] L0_OFS = LEG0_OFS,
    parameter logic [7:0] L1_OFS = LEG1_OFS,
    parameter logic [7:0] MD_OFS = MODE_OFS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CFG_LANES-1:0]  be,
    input  logic [CFG_DATA_W-1:0] wdata,
    input  logic [1:0]            pend,
    output logic [1:0]            clr,
    output logic [1:0]            blk_q,
    output logic [CFG_DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] L0_WORD = ADDR_W'(L0_OFS >> 2);
    localparam logic [ADDR_W-1:0] L1_WORD = ADDR_W'(L1_OFS >> 2);
    localparam logic [ADDR_W-1:0] MD_WORD = ADDR_W'(MD_OFS >> 2);
    localparam int L0_LANE = int'(L0_OFS[1:0]);
    localparam int L1_LANE = int'(L1_OFS[1:0]);
    localparam int MD_LANE = int'(MD_OFS[1:0]);

    logic [7:0] l0_wbyte, l1_wbyte, md_wbyte;
    logic       l0_hit, l1_hit, md_hit;
    logic [7:0] l0_rbyte, l1_rbyte, md_rbyte;

    always_comb begin
        l0_wbyte = wdata[8*L0_LANE +: 8];
        l1_wbyte = wdata[8*L1_LANE +: 8];
        md_wbyte = wdata[8*MD_LANE +: 8];
        l0_hit   = we && (addr == L0_WORD) && be[L0_LANE];
        l1_hit   = we && (addr == L1_WORD) && be[L1_LANE];
        md_hit   = we && (addr == MD_WORD) && be[MD_LANE];
        clr[0]   = (l0_hit && l0_wbyte[LEG0_BIT]) || (md_hit && md_wbyte[MODE_ST0]);
        clr[1]   = (l1_hit && l1_wbyte[LEG1_BIT]) || (md_hit && md_wbyte[MODE_ST1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 2'b00;
        end else if (md_hit) begin
            blk_q <= {md_wbyte[MODE_BLK1], md_wbyte[MODE_BLK0]};
        end
    end

    always_comb begin
        l0_rbyte = 8'h00;
        l1_rbyte = 8'h00;
        md_rbyte = 8'h00;
        l0_rbyte[LEG0_BIT]  = pend[0];
        l1_rbyte[LEG1_BIT]  = pend[1];
        md_rbyte[MODE_ST0]  = pend[0];
        md_rbyte[MODE_ST1]  = pend[1];
        md_rbyte[MODE_BLK0] = blk_q[0];
        md_rbyte[MODE_BLK1] = blk_q[1];
        rdata = '0;
        if (addr == L0_WORD) rdata[8*L0_LANE +: 8] = rdata[8*L0_LANE +: 8] | l0_rbyte;
        if (addr == L1_WORD) rdata[8*L1_LANE +: 8] = rdata[8*L1_LANE +: 8] | l1_rbyte;
        if (addr == MD_WORD) rdata[8*MD_LANE +: 8] = rdata[8*MD_LANE +: 8] | md_rbyte;
    end

    // R7 and R9: block bits move only on an enabled write to the mode byte
    a_r7_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == MD_WORD && be[MD_LANE]) |=> $stable(blk_q));
endmodule

// File: rtl/chan_irq_mirror.sv
module chan_irq_mirror
    import irqm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  chan_req,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] blk;

    irqm_cfg_port u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .pend  (pend),
        .clr   (clr),
        .blk_q (blk),
        .rdata (cfg_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        irqm_chan_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (chan_req[c]),
            .clr   (clr[c]),
            .pend  (pend[c])
        );
    end

    always_comb begin
        irq_out = |(pend & ~blk);
    end

    // R8: both channels blocked keeps the line low
    a_r8_all_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&blk) |-> !irq_out);
    // R8: a pending unblocked channel drives the line
    a_r8_unblocked_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend[0] && !blk[0]) || (pend[1] && !blk[1])) |-> irq_out);
endmodule

// File: tb/chan_irq_mirror_tb.sv
module chan_irq_mirror_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  chan_req;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    logic e_st0, e_st1, e_blk0, e_blk1;

    always #5 clk = ~clk;

    chan_irq_mirror u_dut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_word(input logic [5:0] a);
        case (a)
            6'h14:   return {29'b0, e_st0, 2'b0};
            6'h15:   return {3'b0, e_st1, 28'b0};
            6'h1C:   return {18'b0, e_blk1, e_blk0, e_st1, e_st0, 10'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [5:0] a);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp_word(a));
    endtask

    task automatic check_all(input string req);
        rd_check(req, 6'h14);
        rd_check(req, 6'h15);
        rd_check(req, 6'h1C);
        check(req, {31'b0, irq_out},
              {31'b0, (e_st0 & ~e_blk0) | (e_st1 & ~e_blk1)});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_rise();
        chan_req = 2'b01; tick(); e_st0 = 1;
        check_all("R2 ch0 rise");
        chan_req = 2'b11; tick(); e_st1 = 1;
        check_all("R2 ch1 rise");
    endtask

    task automatic t_byte_enable();
        cfg_write(6'h14, 4'b0000, 32'h0000_0004);
        check_all("R9 no enable");
        cfg_write(6'h14, 4'b1110, 32'hFFFF_FFFF);
        check_all("R9 other lanes");
        cfg_write(6'h1C, 4'b1101, 32'hFFFF_FFFF);
        check_all("R9 mode lane off");
    endtask

    task automatic t_legacy_clear();
        cfg_write(6'h14, 4'b0001, 32'h0000_0004); e_st0 = 0;
        check_all("R4 legacy clear ch0");
        cfg_write(6'h15, 4'b1000, 32'h0000_0000);
        check_all("R4 zero write");
        cfg_write(6'h15, 4'b1000, 32'h1000_0000); e_st1 = 0;
        check_all("R4 legacy clear ch1");
    endtask

    task automatic t_sticky();
        tick(); tick(); tick();
        check_all("R6 held line");
        chan_req = 2'b00; tick();
        check_all("R6 line low");
        chan_req = 2'b11; tick(); e_st0 = 1; e_st1 = 1;
        check_all("R6 rearm");
    endtask

    task automatic t_mode_clear();
        cfg_write(6'h1C, 4'b0010, 32'h0000_0800); e_st1 = 0;
        check_all("R5 mode clear ch1");
        cfg_write(6'h1C, 4'b0010, 32'h0000_0400); e_st0 = 0;
        check_all("R5 mode clear ch0");
    endtask

    task automatic t_no_set();
        cfg_write(6'h1C, 4'b0010, 32'hFFFF_FFFF); e_blk0 = 1; e_blk1 = 1;
        check_all("R4 R7 ones to mode");
        cfg_write(6'h14, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h15, 4'b1111, 32'hFFFF_FFFF);
        check_all("R4 ones to legacy");
        cfg_write(6'h1C, 4'b0010, 32'h0000_0000); e_blk0 = 0; e_blk1 = 0;
        check_all("R7 blocks off");
    endtask

    task automatic t_block();
        chan_req = 2'b00; tick();
        chan_req = 2'b11; tick(); e_st0 = 1; e_st1 = 1;
        check_all("R8 both pending");
        cfg_write(6'h1C, 4'b0010, 32'h0000_1000); e_blk0 = 1;
        check_all("R8 block ch0");
        cfg_write(6'h1C, 4'b0010, 32'h0000_3000); e_blk1 = 1;
        check_all("R8 block both");
        cfg_write(6'h15, 4'b1000, 32'h1000_0000); e_st1 = 0;
        cfg_write(6'h1C, 4'b0010, 32'h0000_2000); e_blk0 = 0;
        check_all("R8 ch0 unblocked");
        cfg_write(6'h1C, 4'b0010, 32'h0000_1000); e_blk0 = 1; e_blk1 = 0;
        check_all("R8 ch1 unblocked idle");
        cfg_write(6'h1C, 4'b0010, 32'h0000_0000); e_blk0 = 0;
        check_all("R7 clear blocks");
    endtask

    task automatic t_fall();
        chan_req = 2'b10; tick(); e_st0 = 0;
        check_all("R3 fall ch0");
        chan_req = 2'b00; tick();
        check_all("R3 fall ch1");
    endtask

    task automatic t_race();
        chan_req = 2'b01;
        cfg_write(6'h14, 4'b0001, 32'h0000_0004); e_st0 = 1;
        check_all("R10 rise beats clear");
        chan_req = 2'b00;
        cfg_write(6'h14, 4'b0001, 32'h0000_0004); e_st0 = 0;
        check_all("R10 fall with clear");
        chan_req = 2'b01; tick(); e_st0 = 1;
        check_all("R10 back in idle");
        chan_req = 2'b00; tick(); e_st0 = 0;
    endtask

    task automatic t_other();
        chan_req = 2'b11; tick(); e_st0 = 1; e_st1 = 1;
        cfg_write(6'h00, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h1D, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h16, 4'b1111, 32'hFFFF_FFFF);
        check_all("R11 stray writes");
        rd_check("R11 read 0x00", 6'h00);
        rd_check("R11 read 0x1D", 6'h1D);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chan_req = 2'b00; cfg_we = 1'b0; cfg_addr = '0;
        cfg_be = '0; cfg_wdata = '0;
        e_st0 = 0; e_st1 = 0; e_blk0 = 0; e_blk1 = 0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_rise();
        t_byte_enable();
        t_legacy_clear();
        t_sticky();
        t_mode_clear();
        t_no_set();
        t_block();
        t_fall();
        t_race();
        t_other();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule